// File: doc/BRIEF.md
# Key-Lock Template Seek Unit

This unit carries out the four search-based control-transfer instructions of a small virtual machine for self-copying code. The machine stores one opcode per memory address. The unit does not decode a jump offset. Instead it walks a seek pointer through memory, one address per clock, until it finds a lock opcode that pairs with the key opcode placed directly after the instruction. When the search ends, the unit does one of two things:

- A jump moves the instruction pointer onto the lock.
- An address capture writes the lock's address into one of four general registers. It then steps past the instruction.

A sequencer starts the unit with a one-cycle request that carries the instruction opcode and the current instruction and seek pointers. The unit reads memory through two combinational read ports: one port is indexed from the instruction pointer and the other from the seek pointer. The unit holds both pointers while it works and shows them on its outputs. It marks the step that retires the instruction with a single-cycle completion pulse. If the cell after the instruction holds no key, the instruction retires at once as a plain step.

Top module: `tmpl_seek`

## Requirements
- R1: Every byte read from memory, and the request opcode, is reduced modulo 64 before it is decoded. Keys occupy values 32..47 and locks occupy values 48..63. A key k pairs only with lock k+16.
- R2: A request is accepted only when the unit is idle and its opcode (mod 64) is one of the following: 5 (search backward, jump), 6 (search forward, jump), 7 (search backward, capture) or 8 (search forward, capture). Any other request leaves every output unchanged.
- R3: If the cell at ip+1 holds no key, the first step retires the instruction. It sets ip to ip+1 and sets sp equal to the new ip.
- R4: Each search step compares the cell at sp with the key at ip+1. On a mismatch, sp moves by exactly one toward the search direction, ip stays unchanged and busy stays high. The step count is therefore the distance to the lock plus one.
- R5: A jump that finds its lock sets ip to the lock address, leaves sp there, and retires in that same step. This also applies when sp starts on the lock.
- R6: A capture that finds its lock takes one more step, which retires the instruction. That step writes the lock address to the register chosen by the cell at ip+2: values 1..4 select registers 0..3, and any other value selects register 0. It then sets ip to ip+1 and sp equal to ip.
- R7: Opcode values of 64 or above act as their residue: a key stored as 96 and a lock stored as 176 still pair.
- R8: Pointer arithmetic wraps modulo the memory size, so sp passes address 0 or the top address without any fault.
- R9: busy is high from the cycle after acceptance until retirement. done is a single-cycle pulse in the retiring cycle, with busy low and sp equal to ip.
- R10: After reset the unit is idle, busy and done are low, and ip, sp, the selector and the write data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle instruction request |
| op_i | input | DW | Instruction opcode |
| ip_i | input | AW | Instruction pointer at request |
| sp_i | input | AW | Seek pointer at request |
| rda_addr_o | output | AW | Read port A address (ip+1, or ip+2 in the write step) |
| rda_data_i | input | DW | Read port A data |
| rdb_addr_o | output | AW | Read port B address (seek pointer) |
| rdb_data_i | input | DW | Read port B data |
| busy_o | output | 1 | Instruction pending |
| done_o | output | 1 | Retirement pulse |
| ip_o | output | AW | Current instruction pointer |
| sp_o | output | AW | Current seek pointer |
| reg_we_o | output | 1 | Register write strobe for capture |
| reg_sel_o | output | 2 | Register index for capture |
| reg_wd_o | output | AW | Captured address |

## Verification
Two events can land in the same cycle: a new request and a search step of an instruction that is still pending. The bench provokes this by pulsing a request with different pointers in the middle of a long forward search. The bench then judges the outcome: the in-flight search must finish at its own lock, with the original ip and the expected step count, and the intruding pointers must not appear on any output. A second coincidence is a match on the very first compare, where key detection and lock detection fall into one step. The bench checks this against a behavioural reference model every cycle.

// File: rtl/tmpl_seek.sv
module tmpl_seek #(
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int NINST     = 64,
  parameter int KEY_BASE  = 32,
  parameter int LOCK_BASE = 48,
  parameter int NPAIR     = 16,
  parameter int RMOD_BASE = 1,
  parameter int OP_BASE   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [DW-1:0] op_i,
  input  logic [AW-1:0] ip_i,
  input  logic [AW-1:0] sp_i,
  output logic [AW-1:0] rda_addr_o,
  input  logic [DW-1:0] rda_data_i,
  output logic [AW-1:0] rdb_addr_o,
  input  logic [DW-1:0] rdb_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] ip_o,
  output logic [AW-1:0] sp_o,
  output logic          reg_we_o,
  output logic [1:0]    reg_sel_o,
  output logic [AW-1:0] reg_wd_o
);
  localparam logic [DW-1:0] MODV  = DW'(NINST);
  localparam logic [DW-1:0] KLO   = DW'(KEY_BASE);
  localparam logic [DW-1:0] KHI   = DW'(KEY_BASE + NPAIR - 1);
  localparam logic [DW-1:0] DLOCK = DW'(LOCK_BASE - KEY_BASE);
  localparam logic [DW-1:0] RLO   = DW'(RMOD_BASE);
  localparam logic [DW-1:0] RHI   = DW'(RMOD_BASE + 3);
  localparam logic [DW-1:0] OLO   = DW'(OP_BASE);
  localparam logic [DW-1:0] OHI   = DW'(OP_BASE + 3);

  typedef enum logic [1:0] {S_IDLE, S_SEEK, S_CAPT} st_t;

  st_t           st_q;
  logic          fwd_q, cap_q;
  logic [AW-1:0] ip_q, sp_q;
  logic [DW-1:0] op_m, a_m, b_m, op_off;
  logic          op_ok, key_ok, hit, rmod_ok;
  logic [AW-1:0] ip_p1, sp_step;

  assign op_m    = op_i % MODV;
  assign a_m     = rda_data_i % MODV;
  assign b_m     = rdb_data_i % MODV;
  assign op_ok   = (op_m >= OLO) && (op_m <= OHI);
  assign op_off  = op_m - OLO;
  assign key_ok  = (a_m >= KLO) && (a_m <= KHI);
  assign hit     = (b_m == a_m + DLOCK);
  assign rmod_ok = (a_m >= RLO) && (a_m <= RHI);
  assign ip_p1   = ip_q + AW'(1);
  assign sp_step = fwd_q ? sp_q + AW'(1) : sp_q - AW'(1);

  assign rda_addr_o = (st_q == S_CAPT) ? ip_q + AW'(2) : ip_p1;
  assign rdb_addr_o = sp_q;
  assign busy_o     = (st_q != S_IDLE);
  assign ip_o       = ip_q;
  assign sp_o       = sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      fwd_q     <= 1'b0;
      cap_q     <= 1'b0;
      ip_q      <= '0;
      sp_q      <= '0;
      done_o    <= 1'b0;
      reg_we_o  <= 1'b0;
      reg_sel_o <= '0;
      reg_wd_o  <= '0;
    end else begin
      done_o   <= 1'b0;
      reg_we_o <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start_i && op_ok) begin
          ip_q  <= ip_i;
          sp_q  <= sp_i;
          fwd_q <= op_off[0];
          cap_q <= op_off[1];
          st_q  <= S_SEEK;
        end
        S_SEEK: begin
          if (!key_ok) begin
            ip_q   <= ip_p1;
            sp_q   <= ip_p1;
            done_o <= 1'b1;
            st_q   <= S_IDLE;
          end else if (hit) begin
            if (cap_q) begin
              st_q <= S_CAPT;
            end else begin
              ip_q   <= sp_q;
              done_o <= 1'b1;
              st_q   <= S_IDLE;
            end
          end else begin
            sp_q <= sp_step;
          end
        end
        S_CAPT: begin
          reg_we_o  <= 1'b1;
          reg_sel_o <= rmod_ok ? 2'(a_m - RLO) : 2'd0;
          reg_wd_o  <= sp_q;
          ip_q      <= ip_p1;
          sp_q      <= ip_p1;
          done_o    <= 1'b1;
          st_q      <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  AST_SP_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_SEEK && $past(st_q) == S_SEEK) |->
      (sp_q == $past(sp_q) + AW'(1) || sp_q == $past(sp_q) - AW'(1))); // R4
  AST_IP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(ip_o)); // R4
  AST_RETIRE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (sp_o == ip_o && !busy_o)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_WRITE_AFTER_CAPT: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> ($past(st_q) == S_CAPT && done_o)); // R6
  AST_JUMP_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == S_SEEK && !$past(cap_q) && done_o && ip_o != $past(ip_q) + AW'(1))
      |-> ip_o == $past(sp_q)); // R5
endmodule

// File: tb/tmpl_seek_tb.sv
module tmpl_seek_tb;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int MS = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [DW-1:0] op_in = '0;
  logic [AW-1:0] ip_in = '0, sp_in = '0;
  logic [AW-1:0] rda_addr, rdb_addr, ip_o, sp_o, reg_wd;
  logic [DW-1:0] rda_data, rdb_data;
  logic busy, done, reg_we;
  logic [1:0] reg_sel;
  logic [7:0] mem [MS];

  int checks = 0, errors = 0, cyc = 0;
  int m_st = 0, m_ip = 0, m_sp = 0, m_sel = 0, m_wd = 0;
  bit m_fwd = 0, m_cap = 0, m_done = 0, m_we = 0;
  string tag = "R10";

  always #10 clk = ~clk;

  assign rda_data = mem[rda_addr];
  assign rdb_data = mem[rdb_addr];

  tmpl_seek #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op_in), .ip_i(ip_in), .sp_i(sp_in),
    .rda_addr_o(rda_addr), .rda_data_i(rda_data), .rdb_addr_o(rdb_addr), .rdb_data_i(rdb_data),
    .busy_o(busy), .done_o(done), .ip_o(ip_o), .sp_o(sp_o),
    .reg_we_o(reg_we), .reg_sel_o(reg_sel), .reg_wd_o(reg_wd));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // behavioural reference, one update per rising edge
  always @(posedge clk) begin
    int k, l, r, o;
    m_done = 0;
    m_we = 0;
    if (!rst_n) begin
      m_st = 0; m_ip = 0; m_sp = 0; m_sel = 0; m_wd = 0; tag = "R10";
    end else if (m_st == 0) begin
      o = int'(op_in) % 64;
      if (start && o >= 5 && o <= 8) begin
        m_ip = ip_in; m_sp = sp_in;
        m_fwd = (o == 6 || o == 8); m_cap = (o >= 7);
        m_st = 1; tag = "R2";
      end
    end else if (m_st == 1) begin
      k = int'(mem[(m_ip + 1) % MS]) % 64;
      l = int'(mem[m_sp]) % 64;
      if (k < 32 || k > 47) begin
        m_ip = (m_ip + 1) % MS; m_sp = m_ip; m_done = 1; m_st = 0; tag = "R3";
      end else if (l - 48 == k - 32) begin
        if (m_cap) begin m_st = 2; tag = "R6"; end
        else begin m_ip = m_sp; m_done = 1; m_st = 0; tag = "R5"; end
      end else begin
        m_sp = m_fwd ? (m_sp + 1) % MS : (m_sp + MS - 1) % MS; tag = "R4";
      end
    end else begin
      r = int'(mem[(m_ip + 2) % MS]) % 64;
      m_sel = (r >= 1 && r <= 4) ? r - 1 : 0;
      m_wd = m_sp; m_we = 1;
      m_ip = (m_ip + 1) % MS; m_sp = m_ip; m_done = 1; m_st = 0; tag = "R6";
    end
  end

  always @(negedge clk) begin
    cyc++;
    check(int'(ip_o) == m_ip, tag, ip_o, m_ip);
    check(int'(sp_o) == m_sp, tag, sp_o, m_sp);
    check(busy == (m_st != 0), "R9", busy, m_st != 0);
    check(done == m_done, "R9", done, m_done);
    check(reg_we == m_we, "R6", reg_we, m_we);
    check(int'(reg_sel) == m_sel, "R6", reg_sel, m_sel);
    check(int'(reg_wd) == m_wd, "R6", reg_wd, m_wd);
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic clear_mem();
    for (int i = 0; i < MS; i++) mem[i] = 8'd0;
  endtask

  task automatic run(input int op, input int ip, input int sp, input bit intrude, output int n);
    @(negedge clk);
    op_in = DW'(op); ip_in = AW'(ip); sp_in = AW'(sp); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 500) begin
      if (intrude && n == 3) begin
        op_in = 8'd6; ip_in = 8'd5; sp_in = 8'd5; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      n++;
    end
    n = n - 1;
  endtask

  initial begin
    int n;
    clear_mem();
    repeat (3) @(negedge clk);
    // R10 reset state
    check(busy == 0 && done == 0, "R10", busy, 0);
    check(ip_o == 0 && sp_o == 0, "R10", ip_o, 0);
    rst_n = 1'b1;

    // R3 no key after instruction
    clear_mem();
    run(6, 20, 99, 0, n);
    check(ip_o == 21 && sp_o == 21, "R3", ip_o, 21);
    check(n == 1, "R3", n, 1);

    // R4 R5 R1 forward jump, foreign lock D skipped before lock C
    clear_mem(); mem[11] = 34; mem[14] = 51; mem[16] = 50;
    run(6, 10, 11, 0, n);
    check(ip_o == 16, "R5", ip_o, 16);
    check(n == 6, "R4", n, 6);

    // R8 backward jump wrapping below zero
    clear_mem(); mem[3] = 47; mem[254] = 63;
    run(5, 2, 2, 0, n);
    check(ip_o == 254 && sp_o == 254, "R8", ip_o, 254);
    check(n == 5, "R8", n, 5);

    // R6 forward capture, selector nop2 -> register 2
    clear_mem(); mem[101] = 33; mem[102] = 3; mem[104] = 49;
    run(8, 100, 101, 0, n);
    check(reg_sel == 2 && reg_wd == 104, "R6", reg_wd, 104);
    check(ip_o == 101 && sp_o == 101 && n == 5, "R6", n, 5);

    // R6 backward capture, non-modifier selector -> register 0
    clear_mem(); mem[151] = 40; mem[152] = 9; mem[145] = 56;
    run(7, 150, 149, 0, n);
    check(reg_sel == 0 && reg_wd == 145, "R6", reg_wd, 145);
    check(ip_o == 151 && n == 6, "R6", n, 6);

    // R7 residues: opcode 70, key 96, lock 176
    clear_mem(); mem[201] = 96; mem[203] = 176;
    run(70, 200, 201, 0, n);
    check(ip_o == 203 && n == 3, "R7", ip_o, 203);

    // R5 lock already under sp
    clear_mem(); mem[31] = 45; mem[40] = 61;
    run(6, 30, 40, 0, n);
    check(ip_o == 40 && n == 1, "R5", ip_o, 40);

    // R8 forward capture wrapping past the top, selector nop3
    clear_mem(); mem[251] = 35; mem[252] = 4; mem[1] = 51;
    run(8, 250, 253, 0, n);
    check(reg_sel == 3 && reg_wd == 1, "R8", reg_wd, 1);
    check(ip_o == 251 && n == 6, "R8", n, 6);

    // R2 unsupported opcode ignored
    @(negedge clk);
    op_in = 8'd9; ip_in = 8'd77; sp_in = 8'd77; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(ip_o == 251 && busy == 0 && done == 0, "R2", ip_o, 251);

    // R2 request during a pending search ignored
    clear_mem(); mem[61] = 36; mem[70] = 52;
    run(6, 60, 61, 1, n);
    check(ip_o == 70 && n == 10, "R2", ip_o, 70);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule